// File: doc/BRIEF.md
# Phase-Token Handshake Pipeline

This block is a linear chain of register stages that move dual-rail words forward without a request or acknowledge wire pair. Each bit travels on two rails, and each bit carries both a logic value and a phase. A stage holds its word until two things are true. First, its input word is complete, meaning every bit shows the phase opposite to the stage's own. Second, its successor has taken the current word, meaning the successor now holds the same phase as the stage. The stage then takes the new word and flips its phase. It then stays frozen until both conditions hold again.

The handshake is modelled as a clocked register transfer. One clock edge is enough for one stage to move. The chain's depth and word width are parameters. A parameter also picks the reset pattern. A full chain has alternating phases and holds one zero-valued token per stage. An empty chain has every stage in phase 0 and holds only bubbles.

The source sees consumption through the first stage's phase. The sink acknowledges a word by driving its acknowledge phase equal to the phase of the output word.

Top module: `phl_chain`

## Requirements
- R1: Bit k of a word occupies rails [2k+1] (rail a) and [2k] (rail b). The logic value of the bit is rail a, and its phase is rail a XOR rail b.
- R2: After reset with FULL_INIT=1, stage i holds value 0 in phase i mod 2. So `src_ack_phase` is 0, `snk_phase` is (DEPTH-1) mod 2, and the output value is 0.
- R3: After reset with FULL_INIT=0, every stage holds value 0 in phase 0. So `src_ack_phase` and `snk_phase` are 0.
- R4: The first stage does not take a source word unless every bit of that word shows the phase opposite to `src_ack_phase`. A word with mixed phases leaves `src_ack_phase` and the output unchanged.
- R5: A stage takes a word only when its successor's phase equals its own. For the last stage, the successor's phase is `snk_ack_phase`. While `snk_ack_phase` differs from `snk_phase`, the output does not change, and a full chain accepts no source word.
- R6: Between captures, a stage's word and phase stay frozen.
- R7: Every word is delivered to the sink once, unaltered and in order. A full-initialised chain first delivers DEPTH zero-valued words.
- R8: Every word at the output is consistent: all of its bits are in the phase reported on `snk_phase`.
- R9: In an empty chain with a ready sink, a word presented to the source reaches the output after exactly DEPTH clock edges.
- R10: Starting from a drained chain with a stalled sink, the chain accepts exactly DEPTH source words and then stops accepting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that paces stage transfers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_rails | input | 2*WIDTH | Dual-rail source word |
| src_ack_phase | output | 1 | Phase of the first stage; equals the source phase once the word is taken |
| snk_rails | output | 2*WIDTH | Dual-rail word held by the last stage |
| snk_phase | output | 1 | Phase of the last stage |
| snk_ack_phase | input | 1 | Sink acknowledge; set equal to `snk_phase` to consume the word |

## Verification
The hardest state to reach from the ports is a chain packed solid, with no bubble anywhere inside it. The other hard case is a source word whose bits are split across two phases. To fill the chain, the bench holds the sink acknowledge still while the source keeps offering fresh phases, and it counts how often the first stage's phase moves. The split word is built by encoding half the bits in the new phase and half in the old one. Streams run with zero, fixed and rotating sink delays in both reset patterns, and every delivered word is compared against its arithmetic expected value.

// File: rtl/phl_pkg.sv
package phl_pkg;
  // Phase of one dual-rail bit: {rail a, rail b}
  function automatic logic phl_bit_phase(input logic [1:0] r);
    return r[1] ^ r[0];
  endfunction

  // Build one rail pair from a value and a phase
  function automatic logic [1:0] phl_bit_enc(input logic v, input logic ph);
    return {v, v ^ ph};
  endfunction
endpackage

// File: rtl/phl_rst_sync.sv
module phl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/phl_cmpd.sv
module phl_cmpd #(
  parameter int WIDTH = 4
) (
  input  logic [2*WIDTH-1:0] rails,
  input  logic               ref_phase,
  output logic               done
);
  import phl_pkg::*;

  logic [WIDTH-1:0] bit_ph;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign bit_ph[k] = phl_bit_phase(rails[2*k+1 -: 2]);
  end

  // complete only when every bit shows the phase opposite to ref_phase
  assign done = ref_phase ? ~|bit_ph : &bit_ph;
endmodule

// File: rtl/phl_stage.sv
module phl_stage #(
  parameter int   WIDTH      = 4,
  parameter logic INIT_PHASE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*WIDTH-1:0] in_rails,
  input  logic               next_phase,
  output logic [2*WIDTH-1:0] out_rails,
  output logic               out_phase
);
  import phl_pkg::*;

  localparam int RW = 2 * WIDTH;

  logic [RW-1:0] rails_q, rails_d, rails_init;
  logic          phase_q, phase_d;
  logic          in_done, take;

  for (genvar k = 0; k < WIDTH; k++) begin : g_init
    assign rails_init[2*k+1 -: 2] = phl_bit_enc(1'b0, INIT_PHASE);
  end

  phl_cmpd #(.WIDTH(WIDTH)) u_cmpd (
    .rails     (in_rails),
    .ref_phase (phase_q),
    .done      (in_done)
  );

  // bubble rule: new word upstream, own word already taken downstream
  assign take = in_done && (next_phase == phase_q);

  always_comb begin
    rails_d = rails_q;
    phase_d = phase_q;
    if (take) begin
      rails_d = in_rails;
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rails_q <= rails_init;
      phase_q <= INIT_PHASE;
    end else if (take) begin
      rails_q <= rails_d;
      phase_q <= phase_d;
    end
  end

  assign out_rails = rails_q;
  assign out_phase = phase_q;
endmodule

// File: rtl/phl_chain.sv
module phl_chain #(
  parameter int WIDTH     = 4,
  parameter int DEPTH     = 4,
  parameter bit FULL_INIT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*WIDTH-1:0] src_rails,
  output logic               src_ack_phase,
  output logic [2*WIDTH-1:0] snk_rails,
  output logic               snk_phase,
  input  logic               snk_ack_phase
);
  localparam int RW = 2 * WIDTH;

  logic          rst_n_int;
  logic [RW-1:0] st_rails [DEPTH];
  logic          st_phase [DEPTH];

  phl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_st
    localparam logic IPH = FULL_INIT ? logic'(i % 2) : 1'b0;
    logic [RW-1:0] in_w;
    logic          nxt_w;

    if (i == 0) begin : g_first
      assign in_w = src_rails;
    end else begin : g_mid
      assign in_w = st_rails[i-1];
    end

    if (i == DEPTH - 1) begin : g_last
      assign nxt_w = snk_ack_phase;
    end else begin : g_inner
      assign nxt_w = st_phase[i+1];
    end

    phl_stage #(.WIDTH(WIDTH), .INIT_PHASE(IPH)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .in_rails   (in_w),
      .next_phase (nxt_w),
      .out_rails  (st_rails[i]),
      .out_phase  (st_phase[i])
    );
  end

  assign src_ack_phase = st_phase[0];
  assign snk_rails     = st_rails[DEPTH-1];
  assign snk_phase     = st_phase[DEPTH-1];
endmodule

// File: rtl/phl_chain_chk.sv
module phl_chain_chk #(
  parameter int WIDTH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*WIDTH-1:0] src_rails,
  input logic               src_ack_phase,
  input logic [2*WIDTH-1:0] snk_rails,
  input logic               snk_phase,
  input logic               snk_ack_phase
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  function automatic logic all_in_phase(input logic [2*WIDTH-1:0] r, input logic ph);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < WIDTH; k++) if ((r[2*k+1] ^ r[2*k]) != ph) ok = 1'b0;
    return ok;
  endfunction

  // R8: output word consistent with reported phase
  a_r8_out_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    all_in_phase(snk_rails, snk_phase));

  // R6: output word frozen while the last stage phase holds
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $stable(snk_phase)) |-> $stable(snk_rails));

  // R5: unconsumed output word is held
  a_r5_sink_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && snk_phase != snk_ack_phase) |=> ($stable(snk_phase) && $stable(snk_rails)));

  // R4: incomplete source word is not taken
  a_r4_src_incomplete: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !all_in_phase(src_rails, ~src_ack_phase)) |=> $stable(src_ack_phase));
endmodule

bind phl_chain phl_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_rails     (src_rails),
  .src_ack_phase (src_ack_phase),
  .snk_rails     (snk_rails),
  .snk_phase     (snk_phase),
  .snk_ack_phase (snk_ack_phase)
);

// File: tb/test_phl_chain.sv
module test_phl_chain;
  localparam int W = 4;
  localparam int D = 4;

  logic clk;
  logic rst_n;
  logic [2*W-1:0] src_rails [2];
  logic           snk_ack   [2];
  logic [2*W-1:0] snk_rails [2];
  logic           src_ack   [2];
  logic           snk_ph    [2];

  int  checks;
  int  fails;
  int  sent [2];
  int  rcv  [2];
  logic sph [2];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // index 0: empty-initialised, index 1: full-initialised
  for (genvar g = 0; g < 2; g++) begin : g_mode
    phl_chain #(.WIDTH(W), .DEPTH(D), .FULL_INIT(g)) i_phl_chain (
      .clk           (clk),
      .rst_n         (rst_n),
      .src_rails     (src_rails[g]),
      .src_ack_phase (src_ack[g]),
      .snk_rails     (snk_rails[g]),
      .snk_phase     (snk_ph[g]),
      .snk_ack_phase (snk_ack[g])
    );
  end

  function automatic int val(input int k);
    return (k * 7 + 3) % 16;
  endfunction

  // R1 encoding: rail a = value, rail b = value ^ phase
  function automatic logic [2*W-1:0] enc(input int v, input logic ph);
    logic [2*W-1:0] r;
    for (int k = 0; k < W; k++) begin
      r[2*k+1] = v[k];
      r[2*k]   = v[k] ^ ph;
    end
    return r;
  endfunction

  function automatic int dec(input logic [2*W-1:0] r);
    int v;
    v = 0;
    for (int k = 0; k < W; k++) v = v | (int'(r[2*k+1]) << k);
    return v;
  endfunction

  function automatic bit consistent(input logic [2*W-1:0] r, input logic ph);
    bit ok;
    ok = 1'b1;
    for (int k = 0; k < W; k++) if ((r[2*k+1] ^ r[2*k]) != ph) ok = 1'b0;
    return ok;
  endfunction

  function automatic int expv(input int m, input int idx);
    if (m == 1) begin
      if (idx < D) return 0;
      return val(idx - D);
    end
    return val(idx);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stream(input int m, input int n, input int dly);
    int lim;
    int off;
    int w;
    int guard;
    lim   = sent[m] + n;
    off   = (m == 1) ? D : 0;
    w     = 0;
    guard = 0;
    while (rcv[m] < lim + off) begin
      @(negedge clk);
      guard++;
      if (guard > 5000) begin
        chk(1'b0, "R7 stream stalled", rcv[m], lim + off);
        break;
      end
      if (sent[m] < lim && src_ack[m] == sph[m]) begin
        sph[m]       = ~sph[m];
        src_rails[m] = enc(val(sent[m]), sph[m]);
        sent[m]++;
      end
      if (snk_ph[m] != snk_ack[m]) begin
        int d;
        d = (dly < 0) ? (rcv[m] % 4) : dly;
        if (w >= d) begin
          chk(dec(snk_rails[m]) == expv(m, rcv[m]), "R7 order/value",
              dec(snk_rails[m]), expv(m, rcv[m]));
          chk(consistent(snk_rails[m], snk_ph[m]), "R8 consistent word", 0, 1);
          snk_ack[m] = snk_ph[m];
          rcv[m]++;
          w = 0;
        end else begin
          w++;
        end
      end
    end
  endtask

  task automatic capacity(input int m);
    int   acc;
    logic prev;
    logic held_ph;
    int   held_v;
    acc  = 0;
    prev = src_ack[m];
    repeat (40) begin
      @(negedge clk);
      if (src_ack[m] != prev) acc++;
      prev = src_ack[m];
      if (src_ack[m] == sph[m]) begin
        sph[m]       = ~sph[m];
        src_rails[m] = enc(val(sent[m]), sph[m]);
        sent[m]++;
      end
    end
    chk(acc == D, "R10 stalled capacity", acc, D);
    held_ph = snk_ph[m];
    held_v  = dec(snk_rails[m]);
    repeat (6) @(negedge clk);
    chk(snk_ph[m] == held_ph && dec(snk_rails[m]) == held_v, "R5 stalled sink holds output",
        dec(snk_rails[m]), held_v);
    chk(dec(snk_rails[m]) == expv(m, rcv[m]), "R6 frozen word intact",
        dec(snk_rails[m]), expv(m, rcv[m]));
    stream(m, 0, 1);
  endtask

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hv;
    checks = 0;
    fails  = 0;
    for (int m = 0; m < 2; m++) begin
      sent[m]      = 0;
      rcv[m]       = 0;
      sph[m]       = 1'b0;
      src_rails[m] = enc(0, 1'b0);
    end
    snk_ack[0] = 1'b0;
    snk_ack[1] = ~logic'((D - 1) % 2);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 empty reset state
    chk(src_ack[0] == 1'b0, "R3 src_ack_phase", src_ack[0], 0);
    chk(snk_ph[0] == 1'b0, "R3 snk_phase", snk_ph[0], 0);
    chk(dec(snk_rails[0]) == 0 && consistent(snk_rails[0], 1'b0), "R3 output word",
        dec(snk_rails[0]), 0);
    // R2 full reset state
    chk(src_ack[1] == 1'b0, "R2 src_ack_phase", src_ack[1], 0);
    chk(snk_ph[1] == logic'((D - 1) % 2), "R2 snk_phase", snk_ph[1], (D - 1) % 2);
    chk(dec(snk_rails[1]) == 0 && consistent(snk_rails[1], snk_ph[1]), "R2 output word",
        dec(snk_rails[1]), 0);

    // R5: full chain with stalled sink refuses the source word
    sph[1]       = 1'b1;
    src_rails[1] = enc(val(0), 1'b1);
    sent[1]      = 1;
    repeat (8) @(negedge clk);
    chk(src_ack[1] == 1'b0, "R5 full chain blocks source", src_ack[1], 0);
    chk(dec(snk_rails[1]) == 0, "R6 full output frozen", dec(snk_rails[1]), 0);

    // R9: latency through the empty chain
    sph[0]       = 1'b1;
    src_rails[0] = enc(val(0), 1'b1);
    sent[0]      = 1;
    repeat (D - 1) @(negedge clk);
    chk(snk_ph[0] == 1'b0, "R9 not yet at output", snk_ph[0], 0);
    @(negedge clk);
    chk(snk_ph[0] == 1'b1, "R9 arrives after DEPTH edges", snk_ph[0], 1);
    chk(dec(snk_rails[0]) == val(0), "R9 value", dec(snk_rails[0]), val(0));
    snk_ack[0] = 1'b1;
    rcv[0]     = 1;
    repeat (D + 1) @(negedge clk);

    // R4: mixed-phase source word is refused (R1 rail layout)
    src_rails[0] = {enc(val(1), 1'b1)[2*W-1:W], enc(val(1), 1'b0)[W-1:0]};
    repeat (6) @(negedge clk);
    chk(src_ack[0] == 1'b1, "R4 mixed word not taken", src_ack[0], 1);
    hv = dec(snk_rails[0]);
    chk(snk_ph[0] == 1'b1 && hv == val(0), "R4 output untouched", hv, val(0));
    sph[0]       = 1'b0;
    src_rails[0] = enc(val(1), 1'b0);
    sent[0]      = 2;

    // R7 streams, empty chain
    stream(0, 20, 0);
    stream(0, 20, 3);
    stream(0, 30, -1);
    capacity(0);

    // R7 streams, full chain (initial zero words come first)
    stream(1, 25, 0);
    stream(1, 20, 2);
    stream(1, 30, -1);
    capacity(1);

    chk(rcv[0] == sent[0], "R7 empty no loss", rcv[0], sent[0]);
    chk(rcv[1] == sent[1] + D, "R7 full no loss", rcv[1], sent[1] + D);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule